// File: doc/BRIEF.md
# Successive-Cancellation Polar Sub-Decoder

This block decodes one polar codeword of configurable length N = 2^n, where n runs from 1 up to the build parameter `LOG_MAX`. It uses the successive-cancellation schedule. On a start pulse it captures a vector of signed fixed-point channel log-likelihood ratios and a frozen-position mask. It then decides the bits one at a time in ascending index order. For every bit it emits the soft LLR that the decision was based on, together with the hard decision.

The datapath is sliced by tree stage. Hardware stage h (0 nearest the channel) holds 2^(LOG_MAX-1-h) processing elements, so the whole tree has 2^LOG_MAX − 1 of them. Each element can compute either a min-sum combine (F) or a sign-conditioned sum (G). A stage computes one of the two per cycle into its own LLR register.

Decided bits are re-encoded by an XOR network that climbs the tree. The result lands in per-stage partial-sum registers, which later G steps consume. A shorter code skips the leading stages: its channel LLRs are steered directly into stage `LOG_MAX − n`.

Top module: `polar_sc_core`

## Requirements
- R1: After reset, `busy`, `out_valid` and `done` are all 0.
- R2: The F step returns sign(a)·sign(b)·min(|a|,|b|). The magnitude of the most negative input code (−2^(W−1)) is taken as 2^(W−1)−1. In a length-2 code, bit 0's LLR is F(llr[0], llr[1]).
- R3: The G step returns b + a when the partial sum is 0 and b − a when it is 1, saturated to [−2^(W−1), 2^(W−1)−1]. In a length-2 code, bit 1's LLR is G(llr[0], llr[1], u0). Longer codes follow the recursive successive-cancellation tree of these two steps, with the encoder x = u·F^{⊗n} and no bit reversal.
- R4: A codeword of length N produces exactly N `out_valid` pulses. Their `out_idx` values are 0, 1, …, N−1 in that order.
- R5: A bit whose `frozen` mask bit is 1 is output with `out_bit` = 0, whatever its LLR.
- R6: A free bit is output as 0 when its LLR is ≥ 0 and as 1 when its LLR is negative.
- R7: `done` pulses together with the `out_valid` of bit N−1. It is visible exactly 2N−2 clock edges after the edge that sampled `start`.
- R8: With `code_log` = n < `LOG_MAX`, only LLR entries and mask bits 0…2^n−1 are used. Entries above them have no effect on the outputs.
- R9: A `start` pulse while `busy` is 1 is ignored, and changes to `llr_in` during decoding have no effect. The running codeword finishes unchanged and `busy` falls after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a codeword (sampled while idle) |
| code_log | input | clog2(LOG_MAX+1) | log2 of the code length, 1…LOG_MAX |
| llr_in | input | 2^LOG_MAX·W | Channel LLRs, entry j at bits [j·W +: W], two's complement |
| frozen | input | 2^LOG_MAX | Bit j set marks index j as frozen |
| out_valid | output | 1 | One decided bit is presented |
| out_idx | output | LOG_MAX | Index of the presented bit |
| out_llr | output | W | Soft LLR of the presented bit |
| out_bit | output | 1 | Hard decision of the presented bit |
| done | output | 1 | Pulses with the last bit of the codeword |
| busy | output | 1 | A codeword is being decoded |

## Verification
The bench builds the block with `LOG_MAX` = 5 and W = 6. This makes the full 32-bit tree with five live stages available, and the 16-, 8-, 4- and 2-bit lengths exercise one to four bypassed stages. Six-bit LLRs let random stimulus reach both saturation rails and the F-magnitude clamp of the most negative code often. Length-2 codes expose single F and G steps for hand-computed checks, and the longer lengths exercise the partial-sum path through several tree levels.

// File: rtl/polar_sc_core.sv
module polar_sc_core #(
  parameter int LOG_MAX = 5,
  parameter int W = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [$clog2(LOG_MAX+1)-1:0]   code_log,
  input  logic [(1<<LOG_MAX)*W-1:0]      llr_in,
  input  logic [(1<<LOG_MAX)-1:0]        frozen,
  output logic                           out_valid,
  output logic [LOG_MAX-1:0]             out_idx,
  output logic [W-1:0]                   out_llr,
  output logic                           out_bit,
  output logic                           done,
  output logic                           busy
);
  localparam int NMAX = 1 << LOG_MAX;
  localparam int IW = LOG_MAX;
  localparam int CW = $clog2(LOG_MAX + 1);
  localparam logic signed [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};

  function automatic logic signed [W-1:0] f_op(input logic signed [W-1:0] x, input logic signed [W-1:0] y);
    logic signed [W-1:0] ax, ay, m;
    ax = x[W-1] ? -x : x;
    ay = y[W-1] ? -y : y;
    if (ax[W-1]) ax = MAXP;
    if (ay[W-1]) ay = MAXP;
    m = (ax < ay) ? ax : ay;
    return (x[W-1] ^ y[W-1]) ? -m : m;
  endfunction

  function automatic logic signed [W-1:0] g_op(input logic signed [W-1:0] x, input logic signed [W-1:0] y, input logic b);
    logic signed [W:0] xe, ye, s;
    xe = (W+1)'(x);
    ye = (W+1)'(y);
    s = b ? (ye - xe) : (ye + xe);
    if (s > (W+1)'(MAXP)) s = (W+1)'(MAXP);
    if (s < (W+1)'(MINN)) s = (W+1)'(MINN);
    return s[W-1:0];
  endfunction

  function automatic logic [CW-1:0] tz(input logic [IW-1:0] v);
    logic [CW-1:0] t;
    t = '0;
    for (int k = IW - 1; k >= 0; k--)
      if (v[k]) t = CW'(k);
    return t;
  endfunction

  logic [NMAX*W-1:0] chan_q;
  logic [NMAX-1:0]   frz_q;
  logic [CW-1:0]     nlog, cur, off, req_log;
  logic              is_g;
  logic [IW-1:0]     idx, last;
  wire  [W-1:0]      leaf;
  wire               ubit, dec;
  wire  [(NMAX-1)*W-1:0] a_all;
  wire  [NMAX-2:0]   bl_all, up_all;

  assign req_log = (code_log == '0) ? CW'(1) : (code_log > CW'(LOG_MAX)) ? CW'(LOG_MAX) : code_log;
  assign off  = CW'(LOG_MAX) - nlog;
  assign last = IW'((32'd1 << nlog) - 32'd1);
  assign dec  = busy && (cur == CW'(LOG_MAX - 1));
  assign ubit = frz_q[idx] ? 1'b0 : leaf[W-1];

  for (genvar h = 0; h < LOG_MAX; h++) begin : stg
    localparam int M = 1 << (LOG_MAX - 1 - h);
    localparam int P = LOG_MAX - 1 - h;
    localparam logic [IW-1:0] LOWM = IW'((1 << P) - 1);
    wire  [2*M*W-1:0] in_v;
    wire  [M*W-1:0]   res;
    wire  [M-1:0]     up;
    wire              store;
    logic [M*W-1:0]   a_q;
    logic [M-1:0]     bl_q;

    if (h == 0) begin : src0
      assign in_v = chan_q;
    end else begin : srcn
      assign in_v = (off == CW'(h)) ? chan_q[2*M*W-1:0] : a_all[(NMAX-4*M)*W +: 2*M*W];
    end

    for (genvar j = 0; j < M; j++) begin : pe
      wire [W-1:0] x = in_v[j*W +: W];
      wire [W-1:0] y = in_v[(j+M)*W +: W];
      assign res[j*W +: W] = is_g ? g_op(x, y, bl_q[j]) : f_op(x, y);
    end

    if (h == LOG_MAX - 1) begin : lf
      assign up = ubit;
      assign leaf = res;
    end else begin : mid
      wire [M/2-1:0] cup = up_all[(NMAX-M) +: M/2];
      wire [M/2-1:0] cbl = bl_all[(NMAX-M) +: M/2];
      assign up = {cup, cup ^ cbl};
    end

    assign store = dec && !idx[P] && ((idx & LOWM) == LOWM);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        a_q  <= '0;
        bl_q <= '0;
      end else begin
        if (busy && cur == CW'(h)) a_q <= res;
        if (store) bl_q <= up;
      end
    end

    assign a_all[(NMAX-2*M)*W +: M*W] = a_q;
    assign bl_all[(NMAX-2*M) +: M] = bl_q;
    assign up_all[(NMAX-2*M) +: M] = up;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; out_valid <= 1'b0; done <= 1'b0;
      out_idx <= '0; out_llr <= '0; out_bit <= 1'b0;
      chan_q <= '0; frz_q <= '0; nlog <= CW'(1);
      cur <= '0; is_g <= 1'b0; idx <= '0;
    end else begin
      out_valid <= 1'b0;
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          chan_q <= llr_in;
          frz_q <= frozen;
          nlog <= req_log;
          cur <= CW'(LOG_MAX) - req_log;
          is_g <= 1'b0;
          idx <= '0;
        end
      end else if (dec) begin
        out_valid <= 1'b1;
        out_idx <= idx;
        out_llr <= leaf;
        out_bit <= ubit;
        if (idx == last) begin
          done <= 1'b1;
          busy <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
          cur <= CW'(LOG_MAX - 1) - tz(idx + 1'b1);
          is_g <= 1'b1;
        end
      end else begin
        cur <= cur + 1'b1;
        is_g <= 1'b0;
      end
    end
  end

  logic [IW-1:0] nxt_exp;
  always_ff @(posedge clk) begin
    if (!rst_n) nxt_exp <= '0;
    else if (start && !busy) nxt_exp <= '0;
    else if (out_valid) nxt_exp <= out_idx + 1'b1;
  end

  p_frozen_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && frz_q[out_idx] |-> !out_bit);
  p_free_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !frz_q[out_idx] |-> out_bit == out_llr[W-1]);
  p_index_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_idx == nxt_exp);
  p_done_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid && out_idx == last);
  p_idle_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_inputs_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(chan_q) && $stable(frz_q));
endmodule

// File: tb/tb_polar_sc_core.sv
module tb_polar_sc_core;
  localparam int CLK_PERIOD = 10;
  localparam int LOG_MAX = 5;
  localparam int W = 6;
  localparam int NMAX = 1 << LOG_MAX;
  localparam int CW = $clog2(LOG_MAX + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [CW-1:0] code_log = CW'(LOG_MAX);
  logic [NMAX*W-1:0] llr_in = '0;
  logic [NMAX-1:0] frozen = '0;
  logic out_valid, out_bit, done, busy;
  logic [LOG_MAX-1:0] out_idx;
  logic [W-1:0] out_llr;

  polar_sc_core #(.LOG_MAX(LOG_MAX), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .code_log(code_log),
    .llr_in(llr_in), .frozen(frozen), .out_valid(out_valid), .out_idx(out_idx),
    .out_llr(out_llr), .out_bit(out_bit), .done(done), .busy(busy));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int ch[NMAX];
  bit fz[NMAX];
  int exp_llr[NMAX];
  bit exp_u[NMAX];
  int dut_llr[NMAX];
  bit dut_bit[NMAX];

  task automatic check(input string tag, input int act, input int expv, input string what);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  function automatic int sat(input int v);
    if (v > 31) return 31;
    if (v < -32) return -32;
    return v;
  endfunction

  function automatic int fref(input int a, input int b);
    int ma, mb, m;
    ma = (a < 0) ? -a : a; if (ma > 31) ma = 31;
    mb = (b < 0) ? -b : b; if (mb > 31) mb = 31;
    m = (ma < mb) ? ma : mb;
    return ((a < 0) != (b < 0)) ? -m : m;
  endfunction

  function automatic int gref(input int a, input int b, input bit s);
    return sat(s ? b - a : b + a);
  endfunction

  task automatic model(input int n);
    int al[NMAX];
    bit enc[NMAX];
    int nn, len, half, base, ii;
    nn = 1 << n;
    for (int i = 0; i < nn; i++) begin
      for (int j = 0; j < nn; j++) al[j] = ch[j];
      len = nn; base = 0; ii = i;
      while (len > 1) begin
        half = len / 2;
        if (ii < half) begin
          for (int j = 0; j < half; j++) al[j] = fref(al[j], al[j+half]);
        end else begin
          for (int j = 0; j < half; j++) enc[j] = exp_u[base+j];
          for (int s = 1; s < half; s = s * 2)
            for (int j = 0; j < half; j++)
              if ((j & s) == 0) enc[j] = enc[j] ^ enc[j+s];
          for (int j = 0; j < half; j++) al[j] = gref(al[j], al[j+half], enc[j]);
          base += half; ii -= half;
        end
        len = half;
      end
      exp_llr[i] = al[0];
      exp_u[i] = fz[i] ? 1'b0 : (al[0] < 0);
    end
  endtask

  task automatic run_cw(input int n, input bit mid, input string tag);
    int nn, cyc, got;
    bit fin;
    nn = 1 << n;
    model(n);
    @(negedge clk);
    for (int j = 0; j < NMAX; j++) begin
      llr_in[j*W +: W] = W'(ch[j]);
      frozen[j] = fz[j];
    end
    code_log = CW'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0; got = 0; fin = 1'b0;
    while (!fin && cyc < 1000) begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (mid && cyc == 3) begin
        start = 1'b1;
        llr_in = {NMAX{6'b100000}};
        frozen = ~frozen;
      end
      if (out_valid) begin
        check(tag, int'(out_idx), got, "bit index");
        check((n == 1 && got == 0) ? "R2" : tag, int'($signed(out_llr)), exp_llr[got], "bit llr");
        check(fz[got] ? "R5" : "R6", int'(out_bit), int'(exp_u[got]), "hard bit");
        if (got < NMAX) begin
          dut_llr[got] = int'($signed(out_llr));
          dut_bit[got] = out_bit;
        end
        got++;
      end
      if (done) begin
        check("R7", cyc, 2*nn - 2, "edges start to done");
        check("R4", got, nn, "bit count");
        fin = 1'b1;
      end
    end
    start = 1'b0;
    if (!fin) check("R7", 0, 1, "done seen");
    @(negedge clk);
    check(mid ? "R9" : "R7", int'(busy), 0, "busy after done");
  endtask

  task automatic fill_rand(input int pct_frozen);
    for (int j = 0; j < NMAX; j++) begin
      ch[j] = int'($urandom_range(0, 63)) - 32;
      fz[j] = ($urandom_range(0, 99) < pct_frozen);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(busy), 0, "busy after reset");
    check("R1", int'(out_valid), 0, "out_valid after reset");
    check("R1", int'(done), 0, "done after reset");

    fill_rand(0); ch[0] = -5; ch[1] = 7; fz[0] = 0; fz[1] = 0;
    run_cw(1, 0, "R3");
    check("R2", dut_llr[0], -5, "F(-5,7)");
    check("R6", int'(dut_bit[0]), 1, "negative free bit");
    check("R3", dut_llr[1], 12, "G with sum 1");

    ch[0] = -32; ch[1] = -32;
    run_cw(1, 0, "R3");
    check("R2", dut_llr[0], 31, "F clamp of most negative");
    check("R3", dut_llr[1], -32, "G lower saturation");

    ch[0] = -5; ch[1] = 7; fz[0] = 1;
    run_cw(1, 0, "R3");
    check("R5", int'(dut_bit[0]), 0, "frozen negative bit");
    check("R3", dut_llr[1], 2, "G with sum 0");

    ch[0] = 20; ch[1] = 25; fz[0] = 0; fz[1] = 0;
    run_cw(1, 0, "R3");
    check("R3", dut_llr[1], 31, "G upper saturation");

    for (int j = 0; j < NMAX; j++) begin ch[j] = 0; fz[j] = 0; end
    run_cw(LOG_MAX, 0, "R6");
    for (int j = 0; j < NMAX; j++) ch[j] = 31;
    run_cw(LOG_MAX, 0, "R3");
    for (int j = 0; j < NMAX; j++) begin ch[j] = -32; fz[j] = 1; end
    run_cw(LOG_MAX, 0, "R5");
    for (int j = 0; j < NMAX; j++) fz[j] = 0;
    run_cw(LOG_MAX, 0, "R3");

    for (int n = 1; n <= LOG_MAX; n++) begin
      fill_rand(50);
      run_cw(n, 0, (n < LOG_MAX) ? "R8" : "R3");
    end

    fill_rand(40);
    run_cw(LOG_MAX, 1, "R9");
    fill_rand(40);
    run_cw(3, 1, "R9");

    for (int t = 0; t < 40; t++) begin
      int n;
      n = int'($urandom_range(1, LOG_MAX));
      fill_rand(int'($urandom_range(0, 100)));
      run_cw(n, 0, (n < LOG_MAX) ? "R8" : "R3");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule